// File: doc/BRIEF.md
# Floating-Point Cumulative Exception Flag Accumulator

This block keeps the sticky floating-point status word of an arithmetic unit. Each completed operation presents eight raw exception indications. These are invalid, divide-by-zero, overflow, underflow, inexact, input denormal flushed, input denormal used and output denormal flushed. The operation also carries a precision tag, a no-accumulate tag and the control bits in force when it ran. The block folds these indications into six cumulative bits. How it maps them depends on the alternate-behaviour mode and on which flush control caused an input flush. A separate saturation strobe sets a sticky saturation bit.

Software replaces the word through a write port. The write keeps only the four condition flags, the saturation bit and the six cumulative bits, and every other bit reads as zero. An operation or saturation event in the same cycle as a write is merged on top of the written value. Trapping is not part of this block.

The status word layout is: invalid at bit 0, divide-by-zero at bit 1, overflow at bit 2, underflow at bit 3, inexact at bit 4, input-denormal at bit 7, saturation at bit 27, and the four condition flags at bits 31:28. All other bits are zero. The raw indication vector `op_raw` uses these indices: 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 input denormal flushed, 6 input denormal used, 7 output denormal flushed. The block has no state machine. It has two states per bit, clear and set. A bit moves from clear to set when an accumulating event occurs. It returns to clear only on a write of zero to that bit or on reset.

Top module: `fpx_exc_accum`

## Requirements
- R1: While `rst_n` is low, and after it is released, `status_o` is all zero until the first write or event.
- R2: An accumulating operation (`op_valid`=1, `op_noacc`=0) with raw invalid, divide-by-zero, overflow or inexact sets status bit 0, 1, 2 or 4 respectively on the next clock edge.
- R3: Raw underflow (index 3) or raw output-denormal-flushed (index 7) sets status bit 3.
- R4: With `ctl_alt`=1, raw output-denormal-flushed also sets status bit 4, and on a single-precision operation raw input-denormal-used (index 6) sets status bit 7.
- R5: On a single-precision operation, raw input-denormal-flushed (index 5) sets status bit 7 only when `ctl_ftz`=1 and `ctl_alt`=0. Raw input-denormal-used has no effect on bit 7 when `ctl_alt`=0.
- R6: An operation with `op_half`=1 never sets status bit 7.
- R7: An operation with `op_noacc`=1 changes no status bit.
- R8: Once set, a status bit stays set through any number of cycles without a write.
- R9: A write (`wr_en`=1) loads bits 31:28, 27, 7 and 4:0 from `wr_data` and zeroes every other bit, so that writing all ones reads back 0xF800009F.
- R10: An accumulating operation in the same cycle as a write is ORed onto the written value.
- R11: `sat_event`=1 sets status bit 27 and it stays set until written. A write in the same cycle as `sat_event` still leaves bit 27 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation's raw indications are present |
| op_half | input | 1 | Operation was half precision |
| op_noacc | input | 1 | Operation must not touch cumulative bits |
| op_raw | input | 8 | Raw exception indications (indices listed above) |
| ctl_alt | input | 1 | Alternate-behaviour mode in force |
| ctl_ftz | input | 1 | Flush-to-zero control in force |
| sat_event | input | 1 | A saturation occurred this cycle |
| wr_en | input | 1 | Software write of the status word |
| wr_data | input | 32 | Value written |
| status_o | output | 32 | Current status word |

## Verification
Every status bit is a registered flop that feeds the port directly. A wrong mapping, a lost sticky value or a mishandled write therefore shows on `status_o` one clock edge after the stimulus that caused it. Once wrong, a stuck or cleared bit stays wrong until the next write, so it is still visible many cycles later. The scoreboard compares the whole word after every driven cycle. A bit that is set when it should stay clear, for example the input-denormal bit on a half-precision operation, is caught on the edge that set it.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int STAT_W = 32;
    localparam int RAW_W  = 8;
    localparam int CUM_W  = 6;
    localparam int CC_W   = 4;

    // raw indication indices
    localparam int RAW_INV = 0;
    localparam int RAW_DZ  = 1;
    localparam int RAW_OF  = 2;
    localparam int RAW_UF  = 3;
    localparam int RAW_IX  = 4;
    localparam int RAW_IDF = 5;
    localparam int RAW_IDU = 6;
    localparam int RAW_ODF = 7;

    // cumulative vector indices
    localparam int C_INV = 0;
    localparam int C_DZ  = 1;
    localparam int C_OF  = 2;
    localparam int C_UF  = 3;
    localparam int C_IX  = 4;
    localparam int C_ID  = 5;

    // status word positions
    localparam int unsigned CUM_POS [CUM_W] = '{0, 1, 2, 3, 4, 7};
    localparam int POS_SAT = 27;
    localparam int POS_CC  = 28;
endpackage

// File: rtl/fpx_flag_map.sv
module fpx_flag_map
    import fpx_pkg::*;
(
    input  logic [RAW_W-1:0] raw,
    input  logic             half,
    input  logic             alt,
    input  logic             ftz,
    output logic [CUM_W-1:0] cum
);
    logic id_from_flush;
    logic id_from_use;

    always_comb begin
        // a flush counts only when caused by flush-to-zero in normal mode
        id_from_flush = raw[RAW_IDF] & ftz & ~alt;
        id_from_use   = raw[RAW_IDU] & alt;

        cum         = '0;
        cum[C_INV]  = raw[RAW_INV];
        cum[C_DZ]   = raw[RAW_DZ];
        cum[C_OF]   = raw[RAW_OF];
        cum[C_UF]   = raw[RAW_UF] | raw[RAW_ODF];
        cum[C_IX]   = raw[RAW_IX] | (alt & raw[RAW_ODF]);
        cum[C_ID]   = ~half & (id_from_flush | id_from_use);
    end
endmodule

// File: rtl/fpx_sticky_bank.sv
module fpx_sticky_bank #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic base;
            always_comb base = wr_en ? wr_val[i] : q[i];
            always_ff @(posedge clk) begin
                if (!rst_n) q[i] <= 1'b0;
                else        q[i] <= base | set[i];
            end
        end
    endgenerate

    // R8: without a write, no set bit ever clears
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((q & $past(q)) == $past(q)));

    // R7: with nothing to set and no write, the bank holds
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && set == '0) |=> $stable(q));

    // R10: a write is merged with same-cycle events
    p_write_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == ($past(wr_val) | $past(set))));
endmodule

// File: rtl/fpx_exc_accum.sv
module fpx_exc_accum
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_half,
    input  logic              op_noacc,
    input  logic [RAW_W-1:0]  op_raw,
    input  logic              ctl_alt,
    input  logic              ctl_ftz,
    input  logic              sat_event,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status_o
);
    logic [CUM_W-1:0] mapped;
    logic [CUM_W-1:0] cum_set;
    logic [CUM_W-1:0] cum_wr;
    logic [CUM_W-1:0] cum_q;
    logic [0:0]       sat_q;
    logic [CC_W-1:0]  cc_q;

    fpx_flag_map u_map (
        .raw  (op_raw),
        .half (op_half),
        .alt  (ctl_alt),
        .ftz  (ctl_ftz),
        .cum  (mapped)
    );

    always_comb begin
        cum_set = (op_valid && !op_noacc) ? mapped : '0;
        for (int i = 0; i < CUM_W; i++) cum_wr[i] = wr_data[CUM_POS[i]];
    end

    fpx_sticky_bank #(.W(CUM_W)) u_cum (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_val (cum_wr),
        .set    (cum_set),
        .q      (cum_q)
    );

    fpx_sticky_bank #(.W(1)) u_sat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_val (wr_data[POS_SAT]),
        .set    (sat_event),
        .q      (sat_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     cc_q <= '0;
        else if (wr_en) cc_q <= wr_data[POS_CC +: CC_W];
    end

    always_comb begin
        status_o = '0;
        status_o[POS_CC +: CC_W] = cc_q;
        status_o[POS_SAT]        = sat_q[0];
        for (int i = 0; i < CUM_W; i++) status_o[CUM_POS[i]] = cum_q[i];
    end

    // R6: half precision never raises the input-denormal bit
    p_half_no_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_half && !wr_en && !status_o[CUM_POS[C_ID]])
        |=> !status_o[CUM_POS[C_ID]]);

    // R9: condition flags follow writes only
    p_cc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (status_o[POS_CC +: CC_W] == $past(wr_data[POS_CC +: CC_W])));

    p_cc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_o[POS_CC +: CC_W]));

    // R11: a saturation event always leaves the bit set
    p_sat_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sat_event |=> status_o[POS_SAT]);
endmodule

// File: tb/tb_fpx_exc_accum.sv
module tb_fpx_exc_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_half = 1'b0, op_noacc = 1'b0;
    logic [7:0]  op_raw = '0;
    logic        ctl_alt = 1'b0, ctl_ftz = 1'b0, sat_event = 1'b0, wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] status_o;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [31:0] mdl = '0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    fpx_exc_accum dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_half(op_half),
        .op_noacc(op_noacc), .op_raw(op_raw), .ctl_alt(ctl_alt),
        .ctl_ftz(ctl_ftz), .sat_event(sat_event), .wr_en(wr_en),
        .wr_data(wr_data), .status_o(status_o)
    );

    function automatic logic [31:0] model(
        input logic [31:0] cur, input logic v, h, na, input logic [7:0] r,
        input logic alt, ftz, sat, we, input logic [31:0] wd);
        logic [31:0] s;
        s = we ? (wd & 32'hF800_009F) : cur;
        if (v && !na) begin
            s[0] |= r[0];
            s[1] |= r[1];
            s[2] |= r[2];
            s[3] |= r[3] | r[7];
            s[4] |= r[4] | (alt & r[7]);
            if (!h) s[7] |= (r[5] & ftz & !alt) | (alt & r[6]);
        end
        if (sat) s[27] = 1'b1;
        return s;
    endfunction

    task automatic drive(input logic v, h, na, input logic [7:0] r,
                         input logic alt, ftz, sat, we, input logic [31:0] wd,
                         input string tag);
        item_t it;
        @(negedge clk);
        op_valid = v; op_half = h; op_noacc = na; op_raw = r;
        ctl_alt = alt; ctl_ftz = ftz; sat_event = sat; wr_en = we; wr_data = wd;
        mdl = model(mdl, v, h, na, r, alt, ftz, sat, we, wd);
        it.exp = mdl;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic op(input logic h, na, input logic [7:0] r,
                      input logic alt, ftz, input string tag);
        drive(1'b1, h, na, r, alt, ftz, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic wr(input logic [31:0] wd, input string tag);
        drive(1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, wd, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, tag);
    endtask

    // monitor: result appears one edge after the driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_vec++;
                if (status_o !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: status_o=%08h expected=%08h", it.tag, status_o, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: expired, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (status_o !== 32'h0) begin
            n_bad++;
            $display("FAIL R1: status_o=%08h expected=00000000", status_o);
        end
        rst_n = 1'b1;
        idle("R1 after release");

        // R2 direct bits
        op(1'b0, 1'b0, 8'b0001_0111, 1'b0, 1'b0, "R2 direct map");
        wr(32'h0, "R9 clear");
        // R3
        op(1'b0, 1'b0, 8'b0000_1000, 1'b0, 1'b0, "R3 underflow");
        wr(32'h0, "R9 clear");
        op(1'b0, 1'b0, 8'b1000_0000, 1'b0, 1'b0, "R3 out denorm normal mode");
        wr(32'h0, "R9 clear");
        // R4
        op(1'b0, 1'b0, 8'b1000_0000, 1'b1, 1'b0, "R4 out denorm alt mode");
        wr(32'h0, "R9 clear");
        op(1'b0, 1'b0, 8'b0100_0000, 1'b1, 1'b0, "R4 in denorm used alt");
        wr(32'h0, "R9 clear");
        // R5
        op(1'b0, 1'b0, 8'b0100_0000, 1'b0, 1'b1, "R5 used ignored normal mode");
        op(1'b0, 1'b0, 8'b0010_0000, 1'b0, 1'b0, "R5 flush by inputs control only");
        op(1'b0, 1'b0, 8'b0010_0000, 1'b1, 1'b1, "R5 flush in alt mode");
        op(1'b0, 1'b0, 8'b0010_0000, 1'b0, 1'b1, "R5 flush by ftz");
        wr(32'h0, "R9 clear");
        // R6
        op(1'b1, 1'b0, 8'b0010_0000, 1'b0, 1'b1, "R6 half flush");
        op(1'b1, 1'b0, 8'b0100_0000, 1'b1, 1'b0, "R6 half used alt");
        // R7
        op(1'b0, 1'b1, 8'hFF, 1'b1, 1'b1, "R7 noacc all flags");
        op(1'b0, 1'b1, 8'hFF, 1'b0, 1'b1, "R7 noacc normal");
        // R8
        op(1'b0, 1'b0, 8'b0000_0001, 1'b0, 1'b0, "R8 set invalid");
        for (int i = 0; i < 5; i++) idle("R8 sticky hold");
        op(1'b0, 1'b0, 8'b0000_0100, 1'b0, 1'b0, "R8 accumulate overflow");
        // R9
        wr(32'hFFFF_FFFF, "R9 write ones");
        wr(32'h5000_0060, "R9 reserved dropped");
        // R10
        drive(1'b1, 1'b0, 1'b0, 8'b0001_0001, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA000_0002,
              "R10 op merged after write");
        drive(1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0,
              "R10 noacc with write");
        // R11
        drive(1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, "R11 sat set");
        for (int i = 0; i < 3; i++) idle("R11 sat sticky");
        wr(32'h0, "R11 write clears sat");
        drive(1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0, "R11 sat with write");
        wr(32'h0800_0000, "R11 write loads sat");
        idle("drain");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule